// File: doc/BRIEF.md
# DRAM Command Decoder and Bank Row Tracker

This block watches the command pins of a DDR4-style memory bus, one sample per clock. Every cycle is sorted into a single command kind. The block also reports the bank that the command targets, the row or column it names, and its option bits. A separate activate strobe marks row opens. When that strobe is high, the three high address pins that carry the row address during an activate are read as the classic three-pin command code.

Alongside the decode, the block keeps one open flag and one stored row for each of the 16 banks. Activates, precharges and auto-precharge accesses update that table. A monitor or protocol checker uses the block to catch illegal traffic: an access to a closed bank, an activate to a bank that is already open, a reserved code, or a mode-register write to a register number that does not exist. Each of these raises a one-cycle error pulse that carries the offending command kind. All outputs are registered and appear one clock after the pins are sampled.

Top module: `dram_cmd_tracker`

## Requirements
- R1: While rst is high at a clock edge, the next outputs are cmd_type 0, err_pulse 0, err_type 0, bank_open all zeros, and all bank, row, column and option outputs zero.
- R2: A cycle with cs_n high is reported one clock later as cmd_type 0 (deselect). No error is raised and bank_open is unchanged, whatever the other pins carry.
- R3: With cs_n low and act_n low, the command is reported as cmd_type 2 (activate). cmd_row equals addr[17:0], including the three pins that otherwise carry the command code, and cmd_bank equals {bg[1],bg[0],ba[1],ba[0]} with bg[1] as the most significant bit.
- R4: With cs_n low and act_n high, the code {addr[16],addr[15],addr[14]} is reported as cmd_type: 111 no-op 1, 110 ZQ calibration 8, 101 read 3, 100 write 4, 011 reserved 9, 010 precharge 5, 001 refresh 6, 000 mode register write 7. No-op, refresh and ZQ calibration leave bank_open unchanged.
- R5: opt_a10 equals addr[10] for read, write, precharge and ZQ calibration and is 0 otherwise. opt_bc equals addr[12] for read and write and is 0 otherwise.
- R6: For a read or write to an open bank, cmd_col equals addr[9:0] and cmd_row equals the row stored by the activate that opened the bank.
- R7: An activate to a closed bank sets bank_open[bank] and stores its row.
- R8: A precharge with addr[10]=0 clears only bank_open[bank]. A precharge with addr[10]=1 clears every bank and reports cmd_bank 0.
- R9: A read or write with addr[10]=1 to an open bank reports the access and clears that bank's open flag at the same edge, so an activate to that bank in the next cycle is legal.
- R10: A read or write to a closed bank, an activate to an open bank, or the reserved code raises err_pulse for one cycle, with err_type equal to cmd_type. An erroneous activate leaves the bank's flag and stored row unchanged. A read or write to a closed bank reports cmd_row 0.
- R11: A mode register write reports the register number {bg[0],ba[1],ba[0]} on cmd_bank and addr[17:0] on cmd_row. Register number 7 raises err_pulse with err_type 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| act_n | input | 1 | Activate strobe, active low |
| bg | input | 2 | Bank group bits |
| ba | input | 2 | Bank address bits |
| addr | input | 18 | Address pins; [16:14] also carry the command code |
| cmd_type | output | 4 | Decoded command kind |
| cmd_bank | output | 4 | Target bank, or register number for a mode write |
| cmd_row | output | 18 | Row address, stored row, or mode register data |
| cmd_col | output | 10 | Column address for read and write |
| opt_a10 | output | 1 | Auto-precharge, all-banks or long-calibration option |
| opt_bc | output | 1 | Burst chop request |
| err_pulse | output | 1 | One-cycle illegal command flag |
| err_type | output | 4 | Command kind that caused the error |
| bank_open | output | 16 | Open flag for each bank |

## Verification
An auto-precharge read reports the row that a bank holds, and at the same edge it closes that bank. An activate to the same bank in the very next cycle must then be judged against the updated table. The bench opens a bank and issues a read with addr[10] set. It checks that the reported row is the stored one and that the bank's flag has dropped. It then drives a new activate to that bank back to back and expects no error, the bank open again, and a later read returning the new row.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [3:0] {
    C_DES = 4'd0,
    C_NOP = 4'd1,
    C_ACT = 4'd2,
    C_RD  = 4'd3,
    C_WR  = 4'd4,
    C_PRE = 4'd5,
    C_REF = 4'd6,
    C_MRS = 4'd7,
    C_ZQC = 4'd8,
    C_RSV = 4'd9
  } cmd_e;

  localparam int CODE_HI = 16;  // pin that doubles as row strobe
  localparam int CODE_LO = 14;  // pin that doubles as write strobe
  localparam int OPT_BIT = 10;
  localparam int BC_BIT  = 12;
endpackage

// File: rtl/dct_decode.sv
module dct_decode
  import dct_pkg::*;
(
  input  logic       cs_n,
  input  logic       act_n,
  input  logic [2:0] code,
  input  logic       a10,
  input  logic       a12,
  output cmd_e       kind,
  output logic       opt_a10,
  output logic       opt_bc
);
  always_comb begin
    kind    = C_DES;
    opt_a10 = 1'b0;
    opt_bc  = 1'b0;
    if (!cs_n) begin
      if (!act_n) begin
        kind = C_ACT;
      end else begin
        unique case (code)
          3'b111: kind = C_NOP;
          3'b110: kind = C_ZQC;
          3'b101: kind = C_RD;
          3'b100: kind = C_WR;
          3'b011: kind = C_RSV;
          3'b010: kind = C_PRE;
          3'b001: kind = C_REF;
          default: kind = C_MRS;
        endcase
        if (kind inside {C_RD, C_WR, C_PRE, C_ZQC}) opt_a10 = a10;
        if (kind inside {C_RD, C_WR}) opt_bc = a12;
      end
    end
  end
endmodule

// File: rtl/dct_bank_table.sv
module dct_bank_table #(
  parameter int BANK_W = 4,
  parameter int ROW_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_we,
  input  logic              clr_one,
  input  logic              clr_all,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row_in,
  output logic [ROW_W-1:0]  row_out,
  output logic [(1<<BANK_W)-1:0] open_vec
);
  localparam int NBANK = 1 << BANK_W;

  logic [ROW_W-1:0] rows [NBANK];

  always_ff @(posedge clk) begin
    if (act_we) rows[bank] <= row_in;
  end

  assign row_out = rows[bank];

  always_ff @(posedge clk) begin
    if (rst) begin
      open_vec <= '0;
    end else if (clr_all) begin
      open_vec <= '0;
    end else if (act_we) begin
      open_vec[bank] <= 1'b1;
    end else if (clr_one) begin
      open_vec[bank] <= 1'b0;
    end
  end

  // R7
  open_set_chk: assert property (@(posedge clk) disable iff (rst)
    act_we |=> open_vec[$past(bank)]);

  // R8
  close_all_chk: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (open_vec == '0));
endmodule

// File: rtl/dram_cmd_tracker.sv
module dram_cmd_tracker
  import dct_pkg::*;
#(
  parameter int BG_W  = 2,
  parameter int BA_W  = 2,
  parameter int ROW_W = 18,
  parameter int COL_W = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n,
  input  logic                       act_n,
  input  logic [BG_W-1:0]            bg,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [3:0]                 cmd_type,
  output logic [BG_W+BA_W-1:0]       cmd_bank,
  output logic [ROW_W-1:0]           cmd_row,
  output logic [COL_W-1:0]           cmd_col,
  output logic                       opt_a10,
  output logic                       opt_bc,
  output logic                       err_pulse,
  output logic [3:0]                 err_type,
  output logic [(1<<(BG_W+BA_W))-1:0] bank_open
);
  localparam int BANK_W = BG_W + BA_W;
  localparam int MR_W   = 3;
  localparam logic [MR_W-1:0] MR_BAD = '1;

  cmd_e              kind;
  logic              d_a10, d_bc;
  logic [BANK_W-1:0] bank_w;
  logic [ROW_W-1:0]  stored_row;
  logic              is_open, err, act_we, clr_one, clr_all;
  logic [BANK_W-1:0] n_bank;
  logic [ROW_W-1:0]  n_row;
  logic [COL_W-1:0]  n_col;

  assign bank_w = {bg, ba};

  dct_decode u_dec (
    .cs_n    (cs_n),
    .act_n   (act_n),
    .code    (addr[CODE_HI:CODE_LO]),
    .a10     (addr[OPT_BIT]),
    .a12     (addr[BC_BIT]),
    .kind    (kind),
    .opt_a10 (d_a10),
    .opt_bc  (d_bc)
  );

  dct_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_tab (
    .clk      (clk),
    .rst      (rst),
    .act_we   (act_we),
    .clr_one  (clr_one),
    .clr_all  (clr_all),
    .bank     (bank_w),
    .row_in   (addr),
    .row_out  (stored_row),
    .open_vec (bank_open)
  );

  always_comb begin
    is_open = bank_open[bank_w];
    err = (kind == C_RSV)
        || ((kind inside {C_RD, C_WR}) && !is_open)
        || ((kind == C_ACT) && is_open)
        || ((kind == C_MRS) && (bank_w[MR_W-1:0] == MR_BAD));
    act_we  = (kind == C_ACT) && !is_open;
    clr_all = (kind == C_PRE) && d_a10;
    clr_one = ((kind == C_PRE) && !d_a10)
            || ((kind inside {C_RD, C_WR}) && d_a10 && is_open);

    n_bank = '0;
    n_row  = '0;
    n_col  = '0;
    unique case (kind)
      C_ACT: begin n_bank = bank_w; n_row = addr; end
      C_RD, C_WR: begin
        n_bank = bank_w;
        n_col  = addr[COL_W-1:0];
        n_row  = is_open ? stored_row : '0;
      end
      C_PRE: n_bank = d_a10 ? '0 : bank_w;
      C_MRS: begin
        n_bank = {{(BANK_W-MR_W){1'b0}}, bank_w[MR_W-1:0]};
        n_row  = addr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_type  <= C_DES;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
      opt_a10   <= 1'b0;
      opt_bc    <= 1'b0;
      err_pulse <= 1'b0;
      err_type  <= C_DES;
    end else begin
      cmd_type  <= kind;
      cmd_bank  <= n_bank;
      cmd_row   <= n_row;
      cmd_col   <= n_col;
      opt_a10   <= d_a10;
      opt_bc    <= d_bc;
      err_pulse <= err;
      err_type  <= err ? kind : C_DES;
    end
  end

  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (cmd_type == C_DES && !err_pulse && $stable(bank_open)));

  // R10
  act_open_err_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !act_n && bank_open[bank_w]) |=> (err_pulse && err_type == C_ACT));

  // R9
  ap_close_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && act_n && addr[CODE_HI:CODE_LO+1] == 2'b10 && addr[OPT_BIT]
     && bank_open[bank_w]) |=> !bank_open[$past(bank_w)]);

  // R10
  err_kind_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (err_type == cmd_type));
endmodule

// File: tb/dram_cmd_tracker_tb.sv
module dram_cmd_tracker_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        act_n = 1'b1;
  logic [1:0]  bg = '0;
  logic [1:0]  ba = '0;
  logic [17:0] addr = '0;
  logic [3:0]  cmd_type, cmd_bank, err_type;
  logic [17:0] cmd_row;
  logic [9:0]  cmd_col;
  logic        opt_a10, opt_bc, err_pulse;
  logic [15:0] bank_open;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  dram_cmd_tracker u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .act_n(act_n), .bg(bg), .ba(ba),
    .addr(addr), .cmd_type(cmd_type), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .opt_a10(opt_a10), .opt_bc(opt_bc),
    .err_pulse(err_pulse), .err_type(err_type), .bank_open(bank_open)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge sample, return at the next falling edge
  task automatic issue(input logic c, input logic a, input logic [3:0] bk, input logic [17:0] ad);
    @(negedge clk);
    cs_n = c; act_n = a; {bg, ba} = bk; addr = ad;
    @(negedge clk);
    cs_n = 1'b1; act_n = 1'b1; addr = '0;
  endtask

  task automatic do_act(input logic [3:0] bk, input logic [17:0] row);
    issue(1'b0, 1'b0, bk, row);
  endtask

  task automatic do_cmd(input logic [2:0] code, input logic [3:0] bk, input logic [17:0] ad);
    logic [17:0] a;
    a = ad;
    a[16:14] = code;
    issue(1'b0, 1'b1, bk, a);
  endtask

  task automatic t_reset;
    check("R1 type", cmd_type, 0);
    check("R1 open", bank_open, 0);
    check("R1 err", err_pulse, 0);
    check("R1 row", cmd_row, 0);
  endtask

  task automatic t_deselect;
    do_act(4'h3, 18'h00111);
    issue(1'b1, 1'b0, 4'h3, 18'h3FFFF);
    check("R2 type", cmd_type, 0);
    check("R2 err", err_pulse, 0);
    check("R2 open", bank_open, 16'h0008);
    do_cmd(3'b010, 4'h0, 18'h00400);
    check("R8 all closed", bank_open, 0);
  endtask

  task automatic t_activate;
    do_act(4'h5, 18'h2ABCD);
    check("R3 type", cmd_type, 2);
    check("R3 row", cmd_row, 18'h2ABCD);
    check("R3 bank", cmd_bank, 5);
    check("R7 open", bank_open, 16'h0020);
    check("R7 err", err_pulse, 0);
  endtask

  task automatic t_decode;
    do_cmd(3'b111, 4'h0, 18'h00400);
    check("R4 nop", cmd_type, 1);
    check("R5 nop a10", opt_a10, 0);
    do_cmd(3'b001, 4'h0, 18'h0);
    check("R4 refresh", cmd_type, 6);
    check("R4 refresh state", bank_open, 16'h0020);
    do_cmd(3'b110, 4'h0, 18'h00400);
    check("R4 zq", cmd_type, 8);
    check("R5 zq long", opt_a10, 1);
    do_cmd(3'b110, 4'h0, 18'h0);
    check("R5 zq short", opt_a10, 0);
  endtask

  task automatic t_rdwr;
    do_cmd(3'b101, 4'h5, 18'h01155);
    check("R4 read", cmd_type, 3);
    check("R6 col", cmd_col, 10'h155);
    check("R6 row", cmd_row, 18'h2ABCD);
    check("R5 bc", opt_bc, 1);
    check("R5 a10", opt_a10, 0);
    check("R6 still open", bank_open, 16'h0020);
    do_cmd(3'b100, 4'h5, 18'h00433);
    check("R4 write", cmd_type, 4);
    check("R9 ap flag", opt_a10, 1);
    check("R9 closed", bank_open, 0);
    check("R9 err", err_pulse, 0);
  endtask

  task automatic t_errors;
    do_cmd(3'b101, 4'h5, 18'h00001);
    check("R10 rd closed err", err_pulse, 1);
    check("R10 rd closed type", err_type, 3);
    check("R10 rd closed row", cmd_row, 0);
    issue(1'b1, 1'b1, 4'h0, 18'h0);
    check("R10 pulse ends", err_pulse, 0);
    do_act(4'h2, 18'h01234);
    do_act(4'h2, 18'h05678);
    check("R10 act open err", err_pulse, 1);
    check("R10 act open type", err_type, 2);
    check("R10 act open state", bank_open, 16'h0004);
    do_cmd(3'b100, 4'h2, 18'h0);
    check("R10 row kept", cmd_row, 18'h01234);
    do_cmd(3'b011, 4'h0, 18'h0);
    check("R10 reserved type", cmd_type, 9);
    check("R10 reserved err", err_type, 9);
    check("R10 reserved state", bank_open, 16'h0004);
  endtask

  task automatic t_precharge;
    do_act(4'h1, 18'h00010);
    do_act(4'h8, 18'h00080);
    check("R7 three open", bank_open, 16'h0106);
    do_cmd(3'b010, 4'h2, 18'h0);
    check("R8 one type", cmd_type, 5);
    check("R8 one bank", cmd_bank, 2);
    check("R8 one closed", bank_open, 16'h0102);
    do_cmd(3'b010, 4'h9, 18'h00400);
    check("R8 all bank", cmd_bank, 0);
    check("R8 all closed", bank_open, 0);
  endtask

  task automatic t_mrs;
    do_cmd(3'b000, 4'h5, 18'h01234);
    check("R11 type", cmd_type, 7);
    check("R11 reg", cmd_bank, 5);
    check("R11 data", cmd_row, 18'h01234);
    check("R11 ok", err_pulse, 0);
    do_cmd(3'b000, 4'h7, 18'h0);
    check("R11 reg7 err", err_pulse, 1);
    check("R11 reg7 type", err_type, 7);
  endtask

  task automatic t_same_cycle;
    do_act(4'h9, 18'h0AAAA);
    do_cmd(3'b101, 4'h9, 18'h00405);
    check("R9 row reported", cmd_row, 18'h0AAAA);
    check("R9 closed same edge", bank_open, 0);
    do_act(4'h9, 18'h15555);
    check("R9 reopen no err", err_pulse, 0);
    check("R9 reopen", bank_open, 16'h0200);
    do_cmd(3'b101, 4'h9, 18'h0);
    check("R6 new row", cmd_row, 18'h15555);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_deselect();
    t_activate();
    t_decode();
    t_rdwr();
    t_errors();
    t_precharge();
    t_mrs();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule